// File: doc/BRIEF.md
# Question-Answer Watchdog Fail Counter

This block supervises a host processor through a question-and-answer watchdog. The watchdog time runs as a series of windows, and the host is expected to write exactly four answers in each one. Each answer write carries two pieces of information: a tag that says whether the answer value was right, and the sequence position that the host believes the answer occupies. A window tick closes the current window. The block then judges the whole window as either good or faulty.

A small saturating fail counter holds the accumulated verdict. It starts high after reset and keeps the power-stage driver disabled. Good windows lower it until the driver may run. Faulty windows raise it. A further fault when the counter is already at its top escalates to a one-cycle reset request, but only when the host has enabled reset escalation.

A status word shows the host two things: how many answers the current window has taken so far, and which kinds of fault have occurred since the last clear. The answer strobe has no back-pressure. The block accepts every strobe in the cycle it is high, so no ready signal exists, and the host must not expect a write to be held off or retried.

Top module: `qawd_supervisor`

## Requirements
- R1: While `rst_n` is low, and after it is released, `fail_cnt` is 5, `drv_en` is 0, `rst_pulse` is 0 and `status` is all zero.
- R2: A window is good when it has exactly four answers, all tagged good, with `ans_seq` equal to 0, 1, 2 and 3 in turn, and no fault. When such a window closes at `win_tick`, `fail_cnt` decreases by one. It never goes below 0. An answer written in the same cycle as the tick counts toward the window that is closing.
- R3: When a faulty window closes, `fail_cnt` increases by exactly one, however many fault causes occurred in it. `fail_cnt` changes only in the cycle after a `win_tick`.
- R4: `drv_en` is 1 exactly when `fail_cnt` is below 5.
- R5: A faulty window that closes while `fail_cnt` is 7 and `rst_en` is 1 does three things in the next cycle: it raises `rst_pulse` for one cycle, reloads `fail_cnt` to 5, and clears `status` to zero.
- R6: A faulty window that closes while `fail_cnt` is 7 and `rst_en` is 0 raises no `rst_pulse`, and `fail_cnt` stays at 7.
- R7: `status[1:0]` holds the number of answers taken in the current window, modulo 4. It returns to 0 in the cycle after every `win_tick`.
- R8: `status[2]` is set when a window closes with fewer than four answers (timeout).
- R9: `status[3]` is set when any of the first four answers in a window is tagged bad (`ans_good` = 0).
- R10: `status[4]` is set when any of the first four answers carries an `ans_seq` that differs from its 0-based position in the window.
- R11: `status[5]` is set by any answer after the fourth in a window. Such an extra answer leaves `status[1:0]` unchanged and makes the window faulty.
- R12: `status[5:2]` are sticky. Only `status_clr` or a reset pulse clears them. A cause that sets a flag in the same cycle as `status_clr` keeps that flag set. `status_clr` changes neither `fail_cnt` nor `status[1:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ans_wr | input | 1 | Answer write strobe, one answer per high cycle |
| ans_good | input | 1 | Answer value was correct |
| ans_seq | input | 2 | Sequence position the host claims for the answer |
| win_tick | input | 1 | One-cycle strobe that closes the current window |
| rst_en | input | 1 | Allow escalation to a reset request |
| status_clr | input | 1 | Clear the sticky fault flags |
| status | output | 6 | {extra, order, value, timeout, answer count[1:0]} |
| fail_cnt | output | 3 | Saturating fail counter |
| drv_en | output | 1 | Power-stage driver enable |
| rst_pulse | output | 1 | One-cycle reset request |

## Verification
The assertions assume three things about the inputs. `win_tick` is a single-cycle strobe. `rst_n` is held low for at least one clock before release. `rst_en` is stable in the cycle of any tick that could escalate.

The bench drives answers and ticks in separate cycles, changes `rst_en` only between windows, and keeps each strobe one cycle wide. Under those conditions the only way the counter can move, step or pulse is through a closing window. The sweep covers every answer count from zero to five, crossed with clean, bad-value and bad-order patterns. It ends with a clear that coincides with a fault cause.

// File: rtl/qawd_pkg.sv
package qawd_pkg;
  // Answers expected per window and the width of the answer counter.
  localparam int ANS_PER_WIN = 4;
  localparam int ANS_W       = $clog2(ANS_PER_WIN);
  // Fail counter geometry.
  localparam int FAIL_W      = 3;
  localparam int FAIL_INIT   = 5;
  localparam int DRV_LIMIT   = 5;
  // Number of sticky fault causes in the status word.
  localparam int NCAUSE      = 4;
  localparam int ST_W        = ANS_W + NCAUSE;

  // Per-cycle fault cause events; order matches status bits above the count.
  typedef struct packed {
    logic extra;
    logic order;
    logic value;
    logic timeout;
  } wd_cause_t;
endpackage

// File: rtl/qawd_answer_track.sv
module qawd_answer_track
  import qawd_pkg::*;
#(
  parameter int ANS_N = ANS_PER_WIN,
  localparam int CW   = $clog2(ANS_N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ans_wr,
  input  logic          ans_good,
  input  logic [CW-1:0] ans_seq,
  input  logic          win_tick,
  output logic [CW-1:0] ans_cnt,
  output logic          win_fault,
  output wd_cause_t     cause_evt
);
  logic [CW-1:0] cnt_q;
  logic          full_q;
  logic          bad_q;
  logic          take;
  logic          last;
  logic          full_eff;

  assign last = (cnt_q == CW'(ANS_N - 1));
  // An answer is taken into the count only while the window is not full.
  assign take = ans_wr && !full_q;

  always_comb begin
    cause_evt         = '0;
    cause_evt.extra   = ans_wr && full_q;
    cause_evt.value   = take && !ans_good;
    cause_evt.order   = take && (ans_seq != cnt_q);
    full_eff          = full_q || (take && last);
    cause_evt.timeout = win_tick && !full_eff;
  end

  // Window verdict, meaningful in the tick cycle; includes same-cycle events.
  assign win_fault = bad_q || cause_evt.value || cause_evt.order ||
                     cause_evt.extra || cause_evt.timeout;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      full_q <= 1'b0;
      bad_q  <= 1'b0;
    end else if (win_tick) begin
      cnt_q  <= '0;
      full_q <= 1'b0;
      bad_q  <= 1'b0;
    end else if (take) begin
      cnt_q  <= last ? '0 : cnt_q + CW'(1);
      full_q <= last;
      bad_q  <= bad_q || cause_evt.value || cause_evt.order;
    end else if (cause_evt.extra) begin
      bad_q  <= 1'b1;
    end
  end

  assign ans_cnt = cnt_q;
endmodule

// File: rtl/qawd_fail_ctr.sv
module qawd_fail_ctr
  import qawd_pkg::*;
#(
  parameter int CNT_W = FAIL_W,
  parameter int INIT  = FAIL_INIT,
  parameter int LIMIT = DRV_LIMIT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             win_tick,
  input  logic             win_fault,
  input  logic             rst_en,
  output logic [CNT_W-1:0] fail_cnt,
  output logic             drv_en,
  output logic             fire,
  output logic             rst_pulse
);
  localparam logic [CNT_W-1:0] TOP  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(INIT);
  localparam logic [CNT_W-1:0] LIM  = CNT_W'(LIMIT);

  logic [CNT_W-1:0] cnt_q;
  logic             at_top;
  logic             at_floor;

  assign at_top   = (cnt_q == TOP);
  assign at_floor = (cnt_q == '0);
  // Escalation: a faulty window that would step past the top.
  assign fire     = win_tick && win_fault && at_top && rst_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q     <= LOAD;
      rst_pulse <= 1'b0;
    end else begin
      rst_pulse <= fire;
      if (win_tick) begin
        if (win_fault) begin
          if (at_top) begin
            if (rst_en) cnt_q <= LOAD;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end else if (!at_floor) begin
          cnt_q <= cnt_q - CNT_W'(1);
        end
      end
    end
  end

  assign fail_cnt = cnt_q;
  assign drv_en   = (cnt_q < LIM);
endmodule

// File: rtl/qawd_status_reg.sv
module qawd_status_reg
  import qawd_pkg::*;
#(
  parameter int AW = ANS_W,
  parameter int NC = NCAUSE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NC-1:0]    cause_set,
  input  logic             clr,
  input  logic             wipe,
  input  logic [AW-1:0]    ans_cnt,
  output logic [AW+NC-1:0] status
);
  logic [NC-1:0] flag_q;

  // One sticky bit per cause; reset pulse wipes, a new cause beats a clear.
  for (genvar k = 0; k < NC; k++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)            flag_q[k] <= 1'b0;
      else if (wipe)         flag_q[k] <= 1'b0;
      else if (cause_set[k]) flag_q[k] <= 1'b1;
      else if (clr)          flag_q[k] <= 1'b0;
    end
  end

  assign status = {flag_q, ans_cnt};
endmodule

// File: rtl/qawd_supervisor.sv
module qawd_supervisor
  import qawd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ans_wr,
  input  logic              ans_good,
  input  logic [ANS_W-1:0]  ans_seq,
  input  logic              win_tick,
  input  logic              rst_en,
  input  logic              status_clr,
  output logic [ST_W-1:0]   status,
  output logic [FAIL_W-1:0] fail_cnt,
  output logic              drv_en,
  output logic              rst_pulse
);
  logic [ANS_W-1:0] ans_cnt;
  logic             win_fault;
  wd_cause_t        cause_evt;
  logic             fire;

  qawd_answer_track #(.ANS_N(ANS_PER_WIN)) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .ans_wr    (ans_wr),
    .ans_good  (ans_good),
    .ans_seq   (ans_seq),
    .win_tick  (win_tick),
    .ans_cnt   (ans_cnt),
    .win_fault (win_fault),
    .cause_evt (cause_evt)
  );

  qawd_fail_ctr #(.CNT_W(FAIL_W), .INIT(FAIL_INIT), .LIMIT(DRV_LIMIT)) u_fail (
    .clk       (clk),
    .rst_n     (rst_n),
    .win_tick  (win_tick),
    .win_fault (win_fault),
    .rst_en    (rst_en),
    .fail_cnt  (fail_cnt),
    .drv_en    (drv_en),
    .fire      (fire),
    .rst_pulse (rst_pulse)
  );

  qawd_status_reg #(.AW(ANS_W), .NC(NCAUSE)) u_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .cause_set (cause_evt),
    .clr       (status_clr),
    .wipe      (fire),
    .ans_cnt   (ans_cnt),
    .status    (status)
  );
endmodule

// File: rtl/qawd_checks.sv
module qawd_checks
  import qawd_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              win_tick,
  input logic              rst_en,
  input logic              status_clr,
  input logic [ST_W-1:0]   status,
  input logic [FAIL_W-1:0] fail_cnt,
  input logic              drv_en,
  input logic              rst_pulse
);
  localparam logic [FAIL_W-1:0] TOP  = {FAIL_W{1'b1}};
  localparam logic [FAIL_W-1:0] LOAD = FAIL_W'(FAIL_INIT);
  localparam logic [FAIL_W-1:0] LIM1 = FAIL_W'(DRV_LIMIT - 1);

  logic past_ok;
  always_ff @(posedge clk) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && !$past(win_tick) |-> fail_cnt == $past(fail_cnt));

  assert_single_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(win_tick) && !rst_pulse |->
      (int'(fail_cnt) - int'($past(fail_cnt)) <= 1) &&
      (int'($past(fail_cnt)) - int'(fail_cnt) <= 1));

  assert_drv_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $rose(drv_en) |-> fail_cnt == LIM1);

  assert_drv_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $fell(drv_en) |-> fail_cnt == LOAD);

  assert_pulse_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pulse |=> !rst_pulse);

  assert_pulse_state_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pulse |-> fail_cnt == LOAD && status == '0);

  assert_pulse_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && rst_pulse |-> $past(rst_en) && $past(fail_cnt) == TOP);

  assert_count_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(win_tick) |-> status[ANS_W-1:0] == '0);

  assert_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && !$past(status_clr) && !rst_pulse |->
      (status[ST_W-1:ANS_W] & $past(status[ST_W-1:ANS_W])) == $past(status[ST_W-1:ANS_W]));
endmodule

bind qawd_supervisor qawd_checks u_qawd_checks (
  .clk        (clk),
  .rst_n      (rst_n),
  .win_tick   (win_tick),
  .rst_en     (rst_en),
  .status_clr (status_clr),
  .status     (status),
  .fail_cnt   (fail_cnt),
  .drv_en     (drv_en),
  .rst_pulse  (rst_pulse)
);

// File: tb/qawd_supervisor_tb_top.sv
`timescale 1ns/1ps
module qawd_supervisor_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ans_wr = 1'b0;
  logic       ans_good = 1'b0;
  logic [1:0] ans_seq = 2'd0;
  logic       win_tick = 1'b0;
  logic       rst_en = 1'b0;
  logic       status_clr = 1'b0;
  logic [5:0] status;
  logic [2:0] fail_cnt;
  logic       drv_en;
  logic       rst_pulse;

  int checks = 0;
  int errors = 0;
  int m_cnt = 5;
  logic [3:0] m_flags = 4'd0;

  always #4 clk = ~clk;

  qawd_supervisor dut_i (
    .clk(clk), .rst_n(rst_n), .ans_wr(ans_wr), .ans_good(ans_good),
    .ans_seq(ans_seq), .win_tick(win_tick), .rst_en(rst_en),
    .status_clr(status_clr), .status(status), .fail_cnt(fail_cnt),
    .drv_en(drv_en), .rst_pulse(rst_pulse)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_state(input string req, input bit exp_pulse);
    chk(fail_cnt == 3'(m_cnt), {req, " fail_cnt"}, fail_cnt, m_cnt);
    chk(drv_en == (m_cnt < 5), "R4 drv_en", drv_en, int'(m_cnt < 5));
    chk(status[5:2] == m_flags, {req, " flags"}, status[5:2], m_flags);
    chk(rst_pulse == exp_pulse, "R5 R6 rst_pulse", rst_pulse, exp_pulse);
  endtask

  // n answers; bv/bo index a bad-value / bad-order answer (-1 none);
  // clr_at indexes an answer cycle that also raises status_clr.
  task automatic run_window(input int n, input int bv, input int bo,
                            input bit ren, input int clr_at);
    bit wbad = 1'b0;
    bit tmo;
    bit pulse = 1'b0;
    rst_en = ren;
    for (int i = 0; i < n; i++) begin
      logic [3:0] nb = 4'd0;
      ans_wr = 1'b1;
      ans_good = (i != bv);
      ans_seq = 2'(i == bo ? i + 1 : i);
      status_clr = (i == clr_at);
      @(negedge clk);
      ans_wr = 1'b0;
      status_clr = 1'b0;
      if (i < 4) begin
        if (i == bv) nb[1] = 1'b1;
        if (i == bo) nb[2] = 1'b1;
      end else begin
        nb[3] = 1'b1;
      end
      wbad = wbad | (|nb);
      m_flags = (i == clr_at) ? nb : (m_flags | nb);
      chk(status[1:0] == 2'(i < 4 ? (i + 1) % 4 : 0), "R7 R11 answer count",
          status[1:0], (i < 4 ? (i + 1) % 4 : 0));
      chk(status[5:2] == m_flags, "R9 R10 R11 R12 flags", status[5:2], m_flags);
    end
    win_tick = 1'b1;
    @(negedge clk);
    win_tick = 1'b0;
    tmo = (n < 4);
    if (wbad || tmo) begin
      if (m_cnt == 7) begin
        if (ren) begin
          pulse = 1'b1;
          m_cnt = 5;
          m_flags = 4'd0;
        end
      end else begin
        m_cnt++;
      end
      if (!pulse && tmo) m_flags[0] = 1'b1;
      chk_state(pulse ? "R5 escalate" : (m_cnt == 7 ? "R3 R6 R8 fault" : "R3 R8 fault"), pulse);
    end else begin
      if (m_cnt > 0) m_cnt--;
      chk_state("R2 good window", 1'b0);
    end
    chk(status[1:0] == 2'd0, "R7 count restart", status[1:0], 0);
    if (pulse) begin
      @(negedge clk);
      chk(rst_pulse == 1'b0, "R5 single cycle", rst_pulse, 0);
    end
  endtask

  task automatic do_clear();
    status_clr = 1'b1;
    @(negedge clk);
    status_clr = 1'b0;
    m_flags = 4'd0;
    chk(status == 6'd0, "R12 clear", status, 0);
    chk(fail_cnt == 3'(m_cnt), "R12 clear keeps count", fail_cnt, m_cnt);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_state("R1 in reset", 1'b0);
    chk(status == 6'd0, "R1 status", status, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_state("R1 after release", 1'b0);
    chk(status == 6'd0, "R1 status", status, 0);

    // Sweep answer counts and fault kinds without escalation.
    for (int n = 0; n <= 5; n++) begin
      for (int kind = 0; kind < 3; kind++) begin
        run_window(n, (kind == 1 && n > 0) ? ((n > 3 ? 3 : n - 1)) : -1,
                   (kind == 2 && n > 0) ? 0 : -1, 1'b0, -1);
        do_clear();
      end
    end

    // Good windows down to and past the floor (R2, R4).
    for (int k = 0; k < 9; k++) run_window(4, -1, -1, 1'b1, -1);
    chk(fail_cnt == 3'd0, "R2 floor", fail_cnt, 0);

    // Climb to the top, saturate without escalation, then escalate.
    for (int k = 0; k < 7; k++) run_window(2, 0, 1, 1'b0, -1);
    chk(fail_cnt == 3'd7, "R3 reach top", fail_cnt, 7);
    run_window(4, 2, -1, 1'b0, -1);
    chk(fail_cnt == 3'd7, "R6 saturate", fail_cnt, 7);
    run_window(5, -1, -1, 1'b1, -1);
    chk(fail_cnt == 3'd5, "R5 reload", fail_cnt, 5);

    // Clear in the same cycle as a new cause: cause wins (R12).
    run_window(1, -1, -1, 1'b0, -1);
    run_window(3, 1, -1, 1'b0, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule